// File: doc/BRIEF.md
# Interval Subprediction Update Unit

This block sits beside one component of a tagged interval predictor and computes the state to be written back into a table entry. It also computes the interval forecast that this state yields. The table supplies the entry's two stored fields, and the caller supplies the interval that was actually observed. The block applies one of four policies: the mean of the last two intervals, a half-weight exponential smoothing, a three-quarter-weight exponential smoothing, or a keep-first policy that freezes the value written when the entry was allocated. Intervals are unsigned and `IVL_W` bits wide, with 6 as the default.

The caller raises `upd_en` when this entry's forecast was used as the final prediction. The caller raises `alloc_en` when a fresh entry is being seeded. One clock later the block presents the new fields and a write strobe. When neither strobe is raised, the registered outputs carry the old fields unchanged, so a table write of them is harmless. The smoothing uses only shifts and adds. Its intermediate sums are two bits wider than an interval, so no carry is lost before the final truncation.

Top module: `ivl_subpred_update`

## Requirements
- R1: Outputs are registered. `wr_out` is high in the cycle after a cycle in which `upd_en` or `alloc_en` was high, and low otherwise.
- R2: With both strobes low, the outputs in the next cycle are `new_a = old_a` and `new_b = old_b`, and the forecast is derived from those fields by the current policy.
- R3: With `alloc_en` high, both `new_a` and `new_b` become `obs_ivl` in every policy, and `sub_pred` equals `obs_ivl`. `alloc_en` takes priority over `upd_en`.
- R4: Mean policy (`mode_sel` = 0). An update shifts the history: `new_a = obs_ivl` and `new_b = old_a`. The forecast is floor((new_a + new_b) / 2).
- R5: Half smoothing (`mode_sel` = 1). An update gives `new_a = floor((obs_ivl + old_a) / 2)` and leaves `new_b = old_b`.
- R6: Three-quarter smoothing (`mode_sel` = 2). An update gives `new_a = floor((3*obs_ivl + old_a) / 4)` and leaves `new_b = old_b`. The result is exact even with both inputs at the maximum value.
- R7: Keep-first (`mode_sel` = 3). An update leaves `new_a = old_a` and `new_b = old_b`.
- R8: In policies 1, 2 and 3, `sub_pred` equals `new_a`.
- R9: While reset is asserted, `new_a`, `new_b`, `sub_pred` and `wr_out` are all zero.
- R10: After any smoothing update, `new_a` lies between `old_a` and `obs_ivl`, inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Entry was used as the final prediction; apply the policy |
| alloc_en | input | 1 | Seed a fresh entry with the observed interval |
| mode_sel | input | 2 | Policy: 0 mean, 1 half smoothing, 2 three-quarter smoothing, 3 keep-first |
| obs_ivl | input | IVL_W | Observed interval |
| old_a | input | IVL_W | Stored field A (newest interval or smoothed value) |
| old_b | input | IVL_W | Stored field B (previous interval, mean policy) |
| new_a | output | IVL_W | Field A to write back |
| new_b | output | IVL_W | Field B to write back |
| sub_pred | output | IVL_W | Forecast derived from the new fields |
| wr_out | output | 1 | The fields changed by a strobe and should be written |

## Verification
On every cycle, the assertions check the strobe timing, the pass-through of fields when no strobe is raised, the seeding on allocation, the frozen value in keep-first, and the fact that a smoothing result stays between its two inputs. Some behaviour only the bench scenarios can show:
- the exact rounded-down values of the mean and of both smoothing weights,
- the saturation corner with both inputs at the maximum,
- the history shift of the mean policy across several updates in a row,
- the priority of allocation over update.

// File: rtl/ivl_pkg.sv
package ivl_pkg;

   typedef enum logic [1:0] {
      POL_MEAN  = 2'd0,
      POL_HALF  = 2'd1,
      POL_3Q    = 2'd2,
      POL_FIRST = 2'd3
   } ivl_policy_e;

   localparam int unsigned IVL_GUARD_BITS = 2;

endpackage

// File: rtl/ivl_pair_mean.sv
module ivl_pair_mean #(
   parameter int unsigned W = 6
) (
   input  logic [W-1:0] val_x,
   input  logic [W-1:0] val_y,
   output logic [W-1:0] mean_out
);
   localparam int unsigned SUM_W = W + 1;

   logic [SUM_W-1:0] pair_sum;

   always_comb begin
      pair_sum = {1'b0, val_x} + {1'b0, val_y};
      mean_out = pair_sum[SUM_W-1:1];
   end

endmodule

// File: rtl/ivl_smoother.sv
module ivl_smoother #(
   parameter int unsigned W     = 6,
   parameter int unsigned NEW_Q = 2
) (
   input  logic [W-1:0] fresh,
   input  logic [W-1:0] prior,
   output logic [W-1:0] blended
);
   localparam int unsigned G     = ivl_pkg::IVL_GUARD_BITS;
   localparam int unsigned SUM_W = W + G;

   logic [SUM_W-1:0] f_ext;
   logic [SUM_W-1:0] p_ext;
   logic [SUM_W-1:0] wsum;

   assign f_ext = {{G{1'b0}}, fresh};
   assign p_ext = {{G{1'b0}}, prior};

   if (NEW_Q < 1 || NEW_Q > 3) begin : g_bad_weight
      $error("ivl_smoother: NEW_Q must be 1, 2 or 3");
   end

   if (NEW_Q == 1) begin : g_q1
      assign wsum = f_ext + (p_ext << 1) + p_ext;
   end else if (NEW_Q == 2) begin : g_q2
      assign wsum = (f_ext << 1) + (p_ext << 1);
   end else begin : g_q3
      assign wsum = (f_ext << 1) + f_ext + p_ext;
   end

   assign blended = wsum[SUM_W-1:G];

endmodule

// File: rtl/ivl_subpred_update.sv
module ivl_subpred_update #(
   parameter int unsigned IVL_W     = 6,
   parameter int unsigned LO_NEW_Q  = 2,
   parameter int unsigned HI_NEW_Q  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_en,
   input  logic             alloc_en,
   input  logic [1:0]       mode_sel,
   input  logic [IVL_W-1:0] obs_ivl,
   input  logic [IVL_W-1:0] old_a,
   input  logic [IVL_W-1:0] old_b,
   output logic [IVL_W-1:0] new_a,
   output logic [IVL_W-1:0] new_b,
   output logic [IVL_W-1:0] sub_pred,
   output logic             wr_out
);
   import ivl_pkg::*;

   localparam int unsigned N_SMOOTH = 2;

   if (IVL_W < 2 || IVL_W > 16) begin : g_bad_width
      $error("ivl_subpred_update: IVL_W must lie in 2..16");
   end
   if (LO_NEW_Q >= HI_NEW_Q) begin : g_bad_order
      $error("ivl_subpred_update: LO_NEW_Q must be below HI_NEW_Q");
   end

   ivl_policy_e      pol;
   logic [IVL_W-1:0] smooth [N_SMOOTH];
   logic [IVL_W-1:0] nxt_a;
   logic [IVL_W-1:0] nxt_b;
   logic [IVL_W-1:0] nxt_mean;
   logic [IVL_W-1:0] nxt_pred;
   logic             strobe;
   logic             primed;

   assign pol    = ivl_policy_e'(mode_sel);
   assign strobe = upd_en | alloc_en;

   for (genvar gi = 0; gi < N_SMOOTH; gi++) begin : g_smooth
      ivl_smoother #(
         .W     (IVL_W),
         .NEW_Q ((gi == 0) ? LO_NEW_Q : HI_NEW_Q)
      ) u_smooth (
         .fresh   (obs_ivl),
         .prior   (old_a),
         .blended (smooth[gi])
      );
   end

   always_comb begin
      nxt_a = old_a;
      nxt_b = old_b;
      if (alloc_en) begin
         nxt_a = obs_ivl;
         nxt_b = obs_ivl;
      end else if (upd_en) begin
         unique case (pol)
            POL_MEAN: begin
               nxt_a = obs_ivl;
               nxt_b = old_a;
            end
            POL_HALF:  nxt_a = smooth[0];
            POL_3Q:    nxt_a = smooth[1];
            POL_FIRST: nxt_a = old_a;
            default:   nxt_a = old_a;
         endcase
      end
   end

   ivl_pair_mean #(.W(IVL_W)) u_mean (
      .val_x    (nxt_a),
      .val_y    (nxt_b),
      .mean_out (nxt_mean)
   );

   assign nxt_pred = (pol == POL_MEAN) ? nxt_mean : nxt_a;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         new_a    <= '0;
         new_b    <= '0;
         sub_pred <= '0;
         wr_out   <= 1'b0;
         primed   <= 1'b0;
      end else begin
         new_a    <= nxt_a;
         new_b    <= nxt_b;
         sub_pred <= nxt_pred;
         wr_out   <= strobe;
         primed   <= 1'b1;
      end
   end

   // Strobe timing
   assert_wr_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (wr_out == ($past(upd_en) || $past(alloc_en))));

   // Idle cycles pass the fields through
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      primed && !$past(upd_en) && !$past(alloc_en)
      |-> (new_a == $past(old_a)) && (new_b == $past(old_b)));

   // Allocation seeds both fields
   assert_alloc_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(alloc_en)
      |-> (new_a == $past(obs_ivl)) && (new_b == $past(obs_ivl)) && (sub_pred == $past(obs_ivl)));

   // Keep-first freezes the entry
   assert_keep_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(upd_en) && !$past(alloc_en) && ($past(mode_sel) == 2'd3)
      |-> (new_a == $past(old_a)) && (new_b == $past(old_b)));

   // Non-mean policies forecast field A
   assert_pred_is_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
      primed && ($past(mode_sel) != 2'd0) |-> (sub_pred == new_a));

   // Smoothing stays between its inputs
   assert_smooth_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(upd_en) && !$past(alloc_en)
      && (($past(mode_sel) == 2'd1) || ($past(mode_sel) == 2'd2))
      |-> ((new_a >= $past(old_a)) || (new_a >= $past(obs_ivl)))
       && ((new_a <= $past(old_a)) || (new_a <= $past(obs_ivl))));

endmodule

// File: tb/test_ivl_subpred_update.sv
`timescale 1ns/1ps
module test_ivl_subpred_update;

   localparam int W    = 6;
   localparam int MAXV = (1 << W) - 1;

   typedef struct {
      int    a;
      int    b;
      int    p;
      int    wr;
      string tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         upd_en = 1'b0;
   logic         alloc_en = 1'b0;
   logic [1:0]   mode_sel = 2'd0;
   logic [W-1:0] obs_ivl = '0;
   logic [W-1:0] old_a = '0;
   logic [W-1:0] old_b = '0;
   logic [W-1:0] new_a;
   logic [W-1:0] new_b;
   logic [W-1:0] sub_pred;
   logic         wr_out;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;
   exp_t sb_q [$];

   always #10 clk = ~clk;

   ivl_subpred_update #(.IVL_W(W)) i_ivl_subpred_update (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (upd_en),
      .alloc_en (alloc_en),
      .mode_sel (mode_sel),
      .obs_ivl  (obs_ivl),
      .old_a    (old_a),
      .old_b    (old_b),
      .new_a    (new_a),
      .new_b    (new_b),
      .sub_pred (sub_pred),
      .wr_out   (wr_out)
   );

   function automatic exp_t model(bit al, bit up, int m, int iv, int oa, int ob, string tag);
      exp_t e;
      e.tag = tag;
      e.a   = oa;
      e.b   = ob;
      e.wr  = (al || up) ? 1 : 0;
      if (al) begin
         e.a = iv;
         e.b = iv;
      end else if (up) begin
         case (m)
            0: begin e.a = iv; e.b = oa; end
            1: e.a = (iv + oa) / 2;
            2: e.a = (3 * iv + oa) / 4;
            default: e.a = oa;
         endcase
      end
      e.p = (m == 0) ? (e.a + e.b) / 2 : e.a;
      return e;
   endfunction

   task automatic drive(bit al, bit up, int m, int iv, int oa, int ob, string tag);
      @(negedge clk);
      alloc_en = al;
      upd_en   = up;
      mode_sel = m[1:0];
      obs_ivl  = iv[W-1:0];
      old_a    = oa[W-1:0];
      old_b    = ob[W-1:0];
      sb_q.push_back(model(al, up, m, iv, oa, ob, tag));
   endtask

   // Scoreboard monitor
   always @(posedge clk) begin
      #2;
      if (rst_n && sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_checks++;
         if (int'(new_a) != e.a || int'(new_b) != e.b || int'(sub_pred) != e.p
             || int'(wr_out) != e.wr) begin
            n_errors++;
            $display("FAIL %s: got a=%0d b=%0d p=%0d wr=%0d, expected a=%0d b=%0d p=%0d wr=%0d",
                     e.tag, new_a, new_b, sub_pred, wr_out, e.a, e.b, e.p, e.wr);
         end
      end
   end

   initial begin
      #4000000;
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      int sa;
      int sb;
      // R9 reset state
      upd_en   = 1'b1;
      alloc_en = 1'b1;
      obs_ivl  = 6'd17;
      repeat (3) @(posedge clk);
      #2;
      n_checks++;
      if (new_a != 0 || new_b != 0 || sub_pred != 0 || wr_out != 0) begin
         n_errors++;
         $display("FAIL R9: got a=%0d b=%0d p=%0d wr=%0d, expected all 0",
                  new_a, new_b, sub_pred, wr_out);
      end
      @(negedge clk);
      upd_en   = 1'b0;
      alloc_en = 1'b0;
      rst_n    = 1'b1;

      // R3 allocation in every policy, and priority over update
      drive(1, 0, 0, 9,  3, 4, "R3 alloc mean");
      drive(1, 0, 1, 21, 3, 4, "R3 alloc half");
      drive(1, 0, 2, 40, 3, 4, "R3 alloc 3q");
      drive(1, 1, 3, 63, 3, 4, "R3 alloc beats update keep");
      drive(1, 1, 1, 0,  50, 60, "R3 alloc beats update half");

      // R4 mean policy, chained history shift and rounding down
      sa = 10; sb = 10;
      drive(0, 1, 0, 13, sa, sb, "R4 mean step1");
      sb = sa; sa = 13;
      drive(0, 1, 0, 20, sa, sb, "R4 mean step2");
      sb = sa; sa = 20;
      drive(0, 1, 0, 63, sa, sb, "R4 mean step3 max");
      drive(0, 1, 0, 63, 63, 62, "R4 mean max");

      // R5 half smoothing
      drive(0, 1, 1, 7,  4,  33, "R5 half odd sum");
      drive(0, 1, 1, 63, 63, 1,  "R5 half max");
      drive(0, 1, 1, 0,  63, 5,  "R5 half low obs");

      // R6 three-quarter smoothing, overflow corner
      drive(0, 1, 2, 63, 63, 2,  "R6 3q max no overflow");
      drive(0, 1, 2, 10, 3,  9,  "R6 3q rounding");
      drive(0, 1, 2, 0,  63, 0,  "R6 3q zero obs");
      drive(0, 1, 2, 63, 0,  0,  "R6 3q zero prior");

      // R7 keep-first
      drive(0, 1, 3, 50, 12, 44, "R7 keep update ignored");
      drive(0, 1, 3, 1,  12, 44, "R7 keep again");

      // R2 idle: no strobe, fields pass through, forecast by policy (R8)
      drive(0, 0, 0, 55, 8,  11, "R2 idle mean");
      drive(0, 0, 2, 55, 30, 11, "R2 idle 3q R8");
      drive(0, 0, 3, 1,  63, 0,  "R2 idle keep R8");

      // R1 strobe timing under a mixed stream, R10 bounds via model
      for (int k = 0; k < 400; k++) begin
         int r;
         r = int'($urandom_range(0, 9));
         drive(r == 0, r >= 4, int'($urandom_range(0, 3)),
               int'($urandom_range(0, MAXV)), int'($urandom_range(0, MAXV)),
               int'($urandom_range(0, MAXV)), "R1 R10 mixed stream");
      end

      @(negedge clk);
      upd_en   = 1'b0;
      alloc_en = 1'b0;
      repeat (3) @(posedge clk);
      #5;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule